// File: doc/BRIEF.md
# Backplane Bus Arbiter with Grant Timeout

This block is the arbitration half of a system controller for a shared parallel backplane. Up to four masters raise active-low request lines. The arbiter hands the bus to one of them by raising that level's grant output. It then watches the active-low bus-busy line to see whether the chosen master really takes the bus. Three arbitration policies can be selected at run time:

- fixed priority;
- a single-level scheme that serves only the top request line;
- a rotating scheme that moves the most recently granted level to the back of the queue.

A granted master may never assert bus-busy. In that case a timeout withdraws the grant, sets a sticky flag and lets arbitration run again. The timeout window is either a short or a long period in microseconds, picked by an input. A prescaler derived from the clock frequency parameter turns microseconds into clock cycles.

An enable input shuts the whole controller off when another board owns system control. A second, independent timer watches data transfers. If a transfer strobe stays active without a slave acknowledge for a set number of microseconds, it produces a one-cycle bus-error pulse. The grant outputs stand in for the head of the grant daisy chain.

Top module: `bkpl_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `grant` is 0, `arb_to_flag` is 0 and `xfer_berr` is 0.
- R2: While `arb_en` is low, `grant` is 0 after every clock edge, whatever the request lines do.
- R3: At most one `grant` bit is ever high, and bit i belongs to `req_n[i]`. A grant is issued at the first clock edge at which the arbiter is idle, `busy_n` is high and an eligible request is low. It appears after that edge.
- R4: With `arb_mode` = 2'b00 or 2'b11 (fixed priority), the highest-numbered requesting level wins.
- R5: With `arb_mode` = 2'b01 (single level), only `req_n[3]` is served. Requests on levels 2..0 are ignored and produce no grant.
- R6: With `arb_mode` = 2'b10 (rotating), after level L is granted the search order is L-1 down to 0 and then LEVELS-1 down to L. After reset, L counts as 0, so the first order is 3,2,1,0.
- R7: A granted master that drives `busy_n` low has its grant removed at the next edge. No further grant is issued until `busy_n` is seen high again; after release a new grant appears two edges later.
- R8: If `busy_n` stays high, a grant stays up for exactly SHORT_US*CLK_PER_US cycles when `long_win`=0, or exactly LONG_US*CLK_PER_US cycles when `long_win`=1. The selection is taken when the grant is issued. The grant then drops, and `arb_to_flag` rises at that same edge.
- R9: `arb_to_flag` stays high until a clock edge with `to_clr` high. A new timeout in the same cycle wins over the clear.
- R10: When `xfer_act` is high with `xfer_ack` low for ACC_US*CLK_PER_US consecutive edges, `xfer_berr` is high for exactly one cycle, after the last of those edges. An acknowledge or a dropped strobe before that restarts the count, and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_en | input | 1 | Enables the system controller on this board |
| arb_mode | input | 2 | Policy: 00/11 priority, 01 single level, 10 rotating |
| long_win | input | 1 | Selects the long arbitration timeout window |
| req_n | input | LEVELS | Active-low bus requests, index = level |
| busy_n | input | 1 | Active-low bus-busy from the current owner |
| grant | output | LEVELS | Active-high one-hot grant per level |
| to_clr | input | 1 | Clears the sticky arbitration timeout flag |
| arb_to_flag | output | 1 | Sticky: a grant was withdrawn unused |
| xfer_act | input | 1 | Data transfer strobe active |
| xfer_ack | input | 1 | Slave acknowledge for the transfer |
| xfer_berr | output | 1 | One-cycle bus-error pulse on access timeout |

## Verification
Every result comes from one register stage, with these latencies:

- A grant appears after the first edge that sees a free bus and an eligible request.
- A grant drops after the first edge that sees `busy_n` low.
- After busy is released, a new grant appears after the second edge.
- The timeout grant lasts exactly the window length in cycles, and the flag rises at the edge that removes it.
- The access error follows the ACC_US*CLK_PER_US-th edge with the strobe pending.

The bench drives inputs on falling edges and samples on the falling edge after the exact number of rising edges worked out above. Timeout lengths are measured by counting the cycles the grant stays high, and the access error is probed one cycle before, at and after its due edge.

// File: rtl/bkpl_arb_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings of the backplane arbiter.
// Assumes: the mode field is two bits wide and the encoding 2'b11 is
// treated as fixed priority.
package bkpl_arb_pkg;

    typedef enum logic [1:0] {
        MODE_PRIO     = 2'b00,
        MODE_SINGLE   = 2'b01,
        MODE_RROBIN   = 2'b10,
        MODE_PRIO_ALT = 2'b11
    } arb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_GRANTED = 2'b01,
        ST_OWNED   = 2'b10
    } arb_state_e;

endpackage

// File: rtl/bkpl_us_window.sv
`timescale 1ns/1ps
// Module: microsecond window timer.
// Counts clock cycles in groups of CLK_PER_US (the prescaler). It raises
// `expire` in the last cycle of a window of `limit` microseconds, measured
// from the first edge at which `run` is high.
// Assumes: `limit` is stable while `run` is high and `limit` >= 1. Dropping
// `run` clears both counters at the next edge. After expiry the count holds,
// so a window fires once per run.
module bkpl_us_window #(
    parameter int CLK_PER_US = 250,
    parameter int CNTW       = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [CNTW-1:0] limit,
    output logic            expire
);
    localparam int SUBW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [SUBW-1:0] SUB_LAST = SUBW'(CLK_PER_US - 1);

    logic [SUBW-1:0] sub_q;
    logic [CNTW-1:0] us_q;

    // Prescaler and microsecond counter; clear when idle, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sub_q <= '0;
            us_q  <= '0;
        end else if (us_q != limit) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                us_q  <= us_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    // Terminal cycle of the window.
    always_comb begin
        expire = run && (us_q == (limit - 1'b1)) && (sub_q == SUB_LAST);
    end

    // R8
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        us_q <= limit);

endmodule

// File: rtl/bkpl_arb_pick.sv
`timescale 1ns/1ps
// Module: combinational winner selection.
// Masks the requests for the chosen policy. It picks the highest level for
// fixed priority, or walks the rotated order that starts just below the
// last granted level for the rotating policy.
// Assumes: `req` is active high, and LEVELS >= 2.
module bkpl_arb_pick
    import bkpl_arb_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDXW   = 2
) (
    input  logic [LEVELS-1:0] req,
    input  arb_mode_e         mode,
    input  logic [IDXW-1:0]   last,
    output logic              win_vld,
    output logic [IDXW-1:0]   win_idx
);
    localparam logic [LEVELS-1:0] TOP_MASK = LEVELS'(1) << (LEVELS - 1);

    logic [LEVELS-1:0] elig;
    logic [IDXW-1:0]   rr_cand [LEVELS];
    logic [IDXW-1:0]   prio_idx;
    logic [IDXW-1:0]   rr_idx;

    // Rotated search order: slot g holds level (last - 1 - g) mod LEVELS.
    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_rot
            assign rr_cand[g] = IDXW'((int'(last) + 2 * LEVELS - 1 - g) % LEVELS);
        end
    endgenerate

    // Apply the single-level mask.
    always_comb begin
        if (mode == MODE_SINGLE) elig = req & TOP_MASK;
        else                     elig = req;
    end

    // Fixed priority: the highest eligible index wins.
    always_comb begin
        prio_idx = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (elig[k]) prio_idx = IDXW'(k);
        end
    end

    // Rotating: the earliest slot in the rotated order wins.
    always_comb begin
        rr_idx = '0;
        for (int k = LEVELS - 1; k >= 0; k--) begin
            if (elig[rr_cand[k]]) rr_idx = rr_cand[k];
        end
    end

    // Final choice by policy.
    always_comb begin
        win_vld = |elig;
        win_idx = (mode == MODE_RROBIN) ? rr_idx : prio_idx;
    end

endmodule

// File: rtl/bkpl_arbiter.sv
`timescale 1ns/1ps
// Module: system-controller bus arbiter (top).
// Grants one request level at a time and waits for the winner to assert
// bus-busy. It withdraws the grant and sets a sticky flag if the winner
// does not take the bus within the selected window. It also times data
// transfers that go unacknowledged.
// Assumes: all inputs are synchronous to clk. req_n and busy_n are active
// low. The grant is one-hot and active high.
module bkpl_arbiter
    import bkpl_arb_pkg::*;
#(
    parameter int LEVELS     = 4,
    parameter int CLK_PER_US = 250,
    parameter int SHORT_US   = 16,
    parameter int LONG_US    = 256,
    parameter int ACC_US     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_en,
    input  logic [1:0]        arb_mode,
    input  logic              long_win,
    input  logic [LEVELS-1:0] req_n,
    input  logic              busy_n,
    output logic [LEVELS-1:0] grant,
    input  logic              to_clr,
    output logic              arb_to_flag,
    input  logic              xfer_act,
    input  logic              xfer_ack,
    output logic              xfer_berr
);
    localparam int IDXW   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int MAX_US = (LONG_US > ACC_US) ? ((LONG_US > SHORT_US) ? LONG_US : SHORT_US)
                                               : ((ACC_US > SHORT_US) ? ACC_US : SHORT_US);
    localparam int CNTW   = $clog2(MAX_US + 1);

    arb_state_e        state_q;
    logic [IDXW-1:0]   last_q;
    logic              lsel_q;
    logic              win_vld;
    logic [IDXW-1:0]   win_idx;
    logic              arb_run;
    logic              arb_expire;
    logic              arb_miss;
    logic [CNTW-1:0]   arb_limit;
    logic              acc_run;
    logic              acc_expire;
    arb_mode_e         mode;

    // Decode the policy input.
    always_comb mode = arb_mode_e'(arb_mode);

    bkpl_arb_pick #(.LEVELS(LEVELS), .IDXW(IDXW)) u_pick (
        .req     (~req_n),
        .mode    (mode),
        .last    (last_q),
        .win_vld (win_vld),
        .win_idx (win_idx)
    );

    // Window length fixed at grant time; timer runs only while a grant waits.
    always_comb begin
        arb_limit = lsel_q ? CNTW'(LONG_US) : CNTW'(SHORT_US);
        arb_run   = arb_en && (state_q == ST_GRANTED);
        arb_miss  = arb_expire && busy_n;
    end

    bkpl_us_window #(.CLK_PER_US(CLK_PER_US), .CNTW(CNTW)) u_arb_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (arb_run),
        .limit  (arb_limit),
        .expire (arb_expire)
    );

    // Access timer runs while a transfer is pending.
    always_comb acc_run = arb_en && xfer_act && !xfer_ack;

    bkpl_us_window #(.CLK_PER_US(CLK_PER_US), .CNTW(CNTW)) u_acc_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (acc_run),
        .limit  (CNTW'(ACC_US)),
        .expire (acc_expire)
    );

    // Arbitration sequencer: idle -> granted -> owned -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant   <= '0;
            last_q  <= '0;
            lsel_q  <= 1'b0;
        end else if (!arb_en) begin
            state_q <= ST_IDLE;
            grant   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (busy_n && win_vld) begin
                        grant   <= LEVELS'(1) << win_idx;
                        last_q  <= win_idx;
                        lsel_q  <= long_win;
                        state_q <= ST_GRANTED;
                    end
                end
                ST_GRANTED: begin
                    if (!busy_n) begin
                        grant   <= '0;
                        state_q <= ST_OWNED;
                    end else if (arb_expire) begin
                        grant   <= '0;
                        state_q <= ST_IDLE;
                    end
                end
                ST_OWNED: begin
                    if (busy_n) state_q <= ST_IDLE;
                end
                default: begin
                    grant   <= '0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Sticky timeout flag; a new miss wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        arb_to_flag <= 1'b0;
        else if (arb_miss) arb_to_flag <= 1'b1;
        else if (to_clr)   arb_to_flag <= 1'b0;
    end

    // Registered bus-error pulse for the access timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_berr <= 1'b0;
        else        xfer_berr <= acc_expire;
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    off_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> (grant == '0));

    // R3
    grant_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|grant) |-> $past(busy_n));

    // R7
    busy_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && !busy_n) |=> (grant == '0));

    // R5
    single_top_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_SINGLE) && (grant == '0)) |=>
            ((grant == '0) || (grant == (LEVELS'(1) << (LEVELS - 1)))));

    // R8
    flag_on_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_to_flag) |-> ((grant == '0) && ($past(grant) != '0)));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_to_flag && !to_clr) |=> arb_to_flag);

    // R10
    berr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_berr |=> !xfer_berr);

    // R10
    berr_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_berr) |-> $past(xfer_act && !xfer_ack));

endmodule

// File: tb/bkpl_arbiter_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, each checking its own results.
// Inputs change on falling edges; outputs are sampled on falling edges.
module bkpl_arbiter_bench;
    localparam int LEVELS = 4;
    localparam int CPU    = 4;
    localparam int SHORT  = 16;
    localparam int LONG   = 256;
    localparam int ACC    = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              arb_en;
    logic [1:0]        arb_mode;
    logic              long_win;
    logic [LEVELS-1:0] req_n;
    logic              busy_n;
    logic [LEVELS-1:0] grant;
    logic              to_clr;
    logic              arb_to_flag;
    logic              xfer_act;
    logic              xfer_ack;
    logic              xfer_berr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bkpl_arbiter #(
        .LEVELS(LEVELS), .CLK_PER_US(CPU), .SHORT_US(SHORT),
        .LONG_US(LONG), .ACC_US(ACC)
    ) u_bkpl_arbiter (
        .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .arb_mode(arb_mode),
        .long_win(long_win), .req_n(req_n), .busy_n(busy_n), .grant(grant),
        .to_clr(to_clr), .arb_to_flag(arb_to_flag), .xfer_act(xfer_act),
        .xfer_ack(xfer_ack), .xfer_berr(xfer_berr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; arb_en = 1'b1; arb_mode = 2'b00; long_win = 1'b0;
        req_n = '1; busy_n = 1'b1; to_clr = 1'b0; xfer_act = 1'b0; xfer_ack = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; arb_en = 1'b1; arb_mode = 2'b00; long_win = 1'b0;
        req_n = '0; busy_n = 1'b1; to_clr = 1'b0; xfer_act = 1'b1; xfer_ack = 1'b0;
        step(3);
        chk("R1 grant in reset", int'(grant), 0);
        chk("R1 flag in reset", int'(arb_to_flag), 0);
        chk("R1 berr in reset", int'(xfer_berr), 0);
        do_reset();
    endtask

    task automatic t_disable();
        do_reset();
        arb_en = 1'b0; req_n = '0;
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk("R2 disabled grant", int'(grant), 0);
        end
        arb_en = 1'b1;
        step(1);
        chk("R3 grant after enable", int'(grant), 4'b1000);
        req_n = '1; busy_n = 1'b0; step(1); busy_n = 1'b1; step(1);
    endtask

    task automatic t_prio();
        do_reset();
        arb_mode = 2'b00;
        busy_n = 1'b0; req_n = 4'b1001;
        step(2);
        chk("R3 no grant while busy", int'(grant), 0);
        busy_n = 1'b1;
        step(1);
        chk("R4 levels 2,1 -> 2", int'(grant), 4'b0100);
        busy_n = 1'b0; req_n = 4'b1101;
        step(1);
        chk("R7 grant drops on busy", int'(grant), 0);
        step(3);
        chk("R7 no grant while owned", int'(grant), 0);
        busy_n = 1'b1;
        step(1);
        chk("R7 one edge after release", int'(grant), 0);
        step(1);
        chk("R7 regrant two edges later", int'(grant), 4'b0010);
        busy_n = 1'b0; req_n = '1; step(1); busy_n = 1'b1; step(1);
        arb_mode = 2'b11; req_n = 4'b0000;
        step(1);
        chk("R4 mode 11 acts as priority", int'(grant), 4'b1000);
        busy_n = 1'b0; req_n = '1; step(1); busy_n = 1'b1; step(1);
    endtask

    task automatic t_single();
        do_reset();
        arb_mode = 2'b01; req_n = 4'b1000;
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk("R5 low levels ignored", int'(grant), 0);
        end
        req_n = 4'b0000;
        step(1);
        chk("R5 top level served", int'(grant), 4'b1000);
        busy_n = 1'b0; req_n = '1; step(1); busy_n = 1'b1; step(1);
    endtask

    task automatic rr_next(input string tag, input int exp);
        busy_n = 1'b0; step(1);
        chk("R6 drop on busy", int'(grant), 0);
        busy_n = 1'b1; step(2);
        chk(tag, int'(grant), exp);
    endtask

    task automatic t_rrobin();
        do_reset();
        arb_mode = 2'b10; req_n = 4'b0000;
        step(1);
        chk("R6 first is 3", int'(grant), 4'b1000);
        rr_next("R6 then 2", 4'b0100);
        rr_next("R6 then 1", 4'b0010);
        rr_next("R6 then 0", 4'b0001);
        rr_next("R6 wraps to 3", 4'b1000);
        req_n = 4'b0101;
        rr_next("R6 sparse 3 -> 1", 4'b0010);
        rr_next("R6 sparse 1 -> 3", 4'b1000);
        busy_n = 1'b0; req_n = '1; step(1); busy_n = 1'b1; step(1);
    endtask

    task automatic measure_timeout(input string tag, input logic lw, input int exp);
        int len;
        long_win = lw; req_n = 4'b1110;
        step(1);
        chk({tag, " grant up"}, int'(grant), 4'b0001);
        long_win = ~lw;
        len = 1;
        for (int i = 0; i < 3000; i++) begin
            step(1);
            if (grant == '0) break;
            len++;
        end
        req_n = '1;
        chk({tag, " grant length"}, len, exp);
        chk({tag, " flag set"}, int'(arb_to_flag), 1);
    endtask

    task automatic t_timeout();
        do_reset();
        arb_mode = 2'b00;
        measure_timeout("R8 short", 1'b0, SHORT * CPU);
        step(10);
        chk("R9 flag sticky", int'(arb_to_flag), 1);
        to_clr = 1'b1; step(1); to_clr = 1'b0;
        chk("R9 flag cleared", int'(arb_to_flag), 0);
        measure_timeout("R8 long", 1'b1, LONG * CPU);
        to_clr = 1'b1; step(1); to_clr = 1'b0;
        req_n = 4'b1110; step(1);
        step(5); busy_n = 1'b0; req_n = '1;
        step(200);
        chk("R8 taken bus no flag", int'(arb_to_flag), 0);
        busy_n = 1'b1; step(2);
    endtask

    task automatic t_access();
        do_reset();
        xfer_act = 1'b1;
        step(ACC * CPU - 1);
        chk("R10 before window", int'(xfer_berr), 0);
        step(1);
        chk("R10 at window", int'(xfer_berr), 1);
        step(1);
        chk("R10 single pulse", int'(xfer_berr), 0);
        xfer_act = 1'b0; step(1);
        xfer_act = 1'b1;
        step(ACC * CPU - 4);
        xfer_ack = 1'b1;
        for (int i = 0; i < 2 * ACC * CPU; i++) begin
            step(1);
            if (xfer_berr) chk("R10 acked no error", 1, 0);
        end
        chk("R10 acked no error end", int'(xfer_berr), 0);
        xfer_act = 1'b0; xfer_ack = 1'b0; step(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_disable();
        t_prio();
        t_single();
        t_rrobin();
        t_timeout();
        t_access();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule